// File: doc/BRIEF.md
# Dual-Point Glitch-Free PWM Generator

This block drives one pulse-width-modulated pin. A two-stage prescaler (a power-of-two stage followed by a linear stage) divides the input clock into a time quantum. An 8-bit position counter advances once per quantum and defines the period. Two compare points, a turn-on point and a turn-off point, set where the pulse sits inside that period.

The period length and both compare points pass through shadow registers. By default, new values are copied in only when the counter wraps, so a change never leaves a period with a torn pulse. A configuration input bypasses the shadow so that new values reach the comparator on the next clock. A run input stops the counter and holds it at zero. A pin-drive input forces the inactive level at once. A polarity input flips the pin at once.

The inactive level is low when polarity is normal and high when it is inverted.

Top module: `pwm_dual_point`

## Requirements
- R1: One quantum lasts (cfgDivLin + 1) << cfgDivShift clocks, and the position counter advances once per quantum. This holds for the smallest setting (both fields zero, one clock per quantum).
- R2: A period lasts (active period + 1) quanta. The counter returns to 0 on the quantum after it reaches or passes the active period. A period value of 0 keeps the counter at 0.
- R3: The registered level is active while the counter is at least the turn-on point and below the turn-off point. When the turn-on point exceeds the turn-off point, the window wraps: the level is active at or above turn-on, or below turn-off. The pin follows the counter one clock later.
- R4: When the active turn-on and turn-off points are equal, the level stays active for the entire period.
- R5: While cfgRun is low, the prescaler, the counter and the level are cleared at every edge. From the next cycle the pin shows the inactive level. After cfgRun rises, the first quantum starts again from zero.
- R6: Period and compare values written while cfgRun is low are in force from the first period after cfgRun rises.
- R7: While cfgDrive is low, pwmOut equals the inactive level in the same cycle. pwmOe always equals cfgDrive.
- R8: cfgInvert flips pwmOut in the same cycle, without waiting for a period boundary.
- R9: With cfgNoSync low, new period and compare values are copied into the active set only at a counter wrap.
- R10: With cfgNoSync high, new period and compare values are copied into the active set at every edge and are used by the comparator on the next clock.
- R11: pwmLive equals pwmOut in every cycle.
- R12: After reset, all counters, the active values and the level are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDivLin | input | 8 | Linear prescaler field (divide by value + 1) |
| cfgDivShift | input | 4 | Power-of-two prescaler field |
| cfgPeriod | input | 8 | Period length in quanta, minus one |
| cfgRise | input | 8 | Turn-on compare point |
| cfgFall | input | 8 | Turn-off compare point |
| cfgRun | input | 1 | Runs the prescaler and counter; low holds them cleared |
| cfgDrive | input | 1 | Lets the generated level reach the pin |
| cfgInvert | input | 1 | Inverts the pin polarity |
| cfgNoSync | input | 1 | Bypasses the period-boundary shadowing |
| pwmOut | output | 1 | PWM pin value |
| pwmOe | output | 1 | Pin output enable |
| pwmLive | output | 1 | Status copy of the pin value |

## Verification
A reference model in the bench predicts the registered level for every cycle. It runs on a single flat prescale count, not the two-stage divider. A plain window at the start of the period, a window that wraps past the period end, and equal compare points separate the three branches of the comparator.

Mid-period edits with shadowing on and with shadowing off show whether values land at the wrap or on the next clock. Toggling polarity and pin drive mid-pulse shows that those paths skip the shadow. A divider and compare change made while stopped, then a restart, shows the clean restart of the quantum. The smallest divider setting exercises the one-clock quantum.

// File: rtl/pwm_dp_pkg.sv
package pwm_dp_pkg;
  typedef struct packed {
    logic qTick;  // a quantum ends this cycle
    logic wrap;   // the position counter returns to zero
    logic clear;  // channel stopped: hold everything at zero
    logic load;   // copy the written values into the active set
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_dp_prescale.sv
module pwm_dp_prescale #(
  parameter int LIN_W   = 8,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic [LIN_W-1:0]   divLin,
  input  logic [SHIFT_W-1:0] divShift,
  output logic               qTick
);
  localparam int SPAN_W = (1 << SHIFT_W) - 1;

  logic [SPAN_W-1:0] shiftCnt;
  logic [SPAN_W-1:0] shiftLimit;
  logic [LIN_W-1:0]  linCnt;
  logic              shiftDone;
  logic              linDone;

  // limit of the power-of-two stage as a thermometer code: 2^divShift - 1
  for (genvar i = 0; i < SPAN_W; i++) begin : g_limit
    assign shiftLimit[i] = (int'(divShift) > i);
  end

  assign shiftDone = (shiftCnt >= shiftLimit);
  assign linDone   = (linCnt >= divLin);
  assign qTick     = !clear && shiftDone && linDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
      linCnt   <= '0;
    end else if (clear) begin
      shiftCnt <= '0;
      linCnt   <= '0;
    end else if (shiftDone) begin
      shiftCnt <= '0;
      linCnt   <= linDone ? '0 : linCnt + 1'b1;
    end else begin
      shiftCnt <= shiftCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_dp_ctrl.sv
module pwm_dp_ctrl
  import pwm_dp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             noSync,
  input  logic             qTick,
  input  logic [CNT_W-1:0] actPeriod,
  output logic [CNT_W-1:0] perCnt,
  output pwm_strobe_t      strb
);
  logic atEnd;

  assign atEnd      = (perCnt >= actPeriod);
  assign strb.qTick = qTick;
  assign strb.clear = !run;
  assign strb.wrap  = qTick && atEnd;
  assign strb.load  = !run || noSync || (qTick && atEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt <= '0;
    end else if (!run) begin
      perCnt <= '0;
    end else if (qTick) begin
      perCnt <= atEnd ? '0 : perCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_dp_datapath.sv
module pwm_dp_datapath
  import pwm_dp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwm_strobe_t      strb,
  input  logic [CNT_W-1:0] perCnt,
  input  logic [CNT_W-1:0] newPeriod,
  input  logic [CNT_W-1:0] newRise,
  input  logic [CNT_W-1:0] newFall,
  output logic [CNT_W-1:0] actPeriod,
  output logic [CNT_W-1:0] actRise,
  output logic [CNT_W-1:0] actFall,
  output logic             levelQ
);
  logic inWindow;

  always_comb begin
    if (actRise == actFall)
      inWindow = 1'b1;
    else if (actRise < actFall)
      inWindow = (perCnt >= actRise) && (perCnt < actFall);
    else
      inWindow = (perCnt >= actRise) || (perCnt < actFall);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPeriod <= '0;
      actRise   <= '0;
      actFall   <= '0;
    end else if (strb.load) begin
      actPeriod <= newPeriod;
      actRise   <= newRise;
      actFall   <= newFall;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           levelQ <= 1'b0;
    else if (strb.clear) levelQ <= 1'b0;
    else                 levelQ <= inWindow;
  end
endmodule

// File: rtl/pwm_dual_point.sv
module pwm_dual_point
  import pwm_dp_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LIN_W   = 8,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LIN_W-1:0]   cfgDivLin,
  input  logic [SHIFT_W-1:0] cfgDivShift,
  input  logic [CNT_W-1:0]   cfgPeriod,
  input  logic [CNT_W-1:0]   cfgRise,
  input  logic [CNT_W-1:0]   cfgFall,
  input  logic               cfgRun,
  input  logic               cfgDrive,
  input  logic               cfgInvert,
  input  logic               cfgNoSync,
  output logic               pwmOut,
  output logic               pwmOe,
  output logic               pwmLive
);
  pwm_strobe_t      strb;
  logic             qTick;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] actPeriod;
  logic [CNT_W-1:0] actRise;
  logic [CNT_W-1:0] actFall;
  logic             levelQ;

  pwm_dp_prescale #(.LIN_W(LIN_W), .SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rstN(rstN), .clear(!cfgRun),
    .divLin(cfgDivLin), .divShift(cfgDivShift), .qTick(qTick)
  );

  pwm_dp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(cfgRun), .noSync(cfgNoSync),
    .qTick(qTick), .actPeriod(actPeriod), .perCnt(perCnt), .strb(strb)
  );

  pwm_dp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .perCnt(perCnt),
    .newPeriod(cfgPeriod), .newRise(cfgRise), .newFall(cfgFall),
    .actPeriod(actPeriod), .actRise(actRise), .actFall(actFall),
    .levelQ(levelQ)
  );

  // polarity and pin drive act at once, outside the shadowed path
  assign pwmOut  = (cfgDrive & levelQ) ^ cfgInvert;
  assign pwmOe   = cfgDrive;
  assign pwmLive = pwmOut;
endmodule

// File: rtl/pwm_dp_checker.sv
module pwm_dp_checker
  import pwm_dp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgRun,
  input logic             cfgDrive,
  input logic             cfgInvert,
  input logic             cfgNoSync,
  input logic [CNT_W-1:0] cfgRise,
  input logic [CNT_W-1:0] cfgFall,
  input logic [CNT_W-1:0] perCnt,
  input logic [CNT_W-1:0] actPeriod,
  input logic [CNT_W-1:0] actRise,
  input logic [CNT_W-1:0] actFall,
  input logic             levelQ,
  input logic             pwmOut,
  input pwm_strobe_t      strb
);
  assert_tick_moves_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRun && !strb.qTick) |=> $stable(perCnt));

  assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRun |=> (perCnt == '0 && !levelQ));

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRun && actRise == actFall) |=> levelQ);

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRun && !cfgNoSync && !strb.wrap) |=>
      ($stable(actRise) && $stable(actFall) && $stable(actPeriod)));

  assert_bypass_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgNoSync |=> (actRise == $past(cfgRise) && actFall == $past(cfgFall)));

  assert_pin_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDrive |-> (pwmOut == cfgInvert));
endmodule

bind pwm_dual_point pwm_dp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgRun(cfgRun), .cfgDrive(cfgDrive),
  .cfgInvert(cfgInvert), .cfgNoSync(cfgNoSync), .cfgRise(cfgRise),
  .cfgFall(cfgFall), .perCnt(perCnt), .actPeriod(actPeriod),
  .actRise(actRise), .actFall(actFall), .levelQ(levelQ),
  .pwmOut(pwmOut), .strb(strb)
);

// File: tb/pwm_dual_point_tb.sv
module pwm_dual_point_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgDivLin = 8'd1;
  logic [3:0] cfgDivShift = 4'd1;
  logic [7:0] cfgPeriod = 8'd7;
  logic [7:0] cfgRise = 8'd0;
  logic [7:0] cfgFall = 8'd3;
  logic       cfgRun = 1'b0;
  logic       cfgDrive = 1'b1;
  logic       cfgInvert = 1'b0;
  logic       cfgNoSync = 1'b0;
  logic       pwmOut, pwmOe, pwmLive;

  int    checks = 0;
  int    errors = 0;
  int    cycleNo = 0;
  bit    done = 0;
  string phase = "R12";
  bit    expQ[$];

  // reference model state
  int mPre = 0, mCnt = 0, mPer = 0, mRise = 0, mFall = 0;
  bit mLevel = 0;

  always #4 clk = ~clk;

  pwm_dual_point u_dut (
    .clk(clk), .rstN(rstN), .cfgDivLin(cfgDivLin), .cfgDivShift(cfgDivShift),
    .cfgPeriod(cfgPeriod), .cfgRise(cfgRise), .cfgFall(cfgFall),
    .cfgRun(cfgRun), .cfgDrive(cfgDrive), .cfgInvert(cfgInvert),
    .cfgNoSync(cfgNoSync), .pwmOut(pwmOut), .pwmOe(pwmOe), .pwmLive(pwmLive)
  );

  function automatic bit window(int c, int r, int f);
    if (r == f) return 1'b1;
    if (r < f)  return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  // model: predicts the registered level after every edge, queued for the monitor
  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mPer = 0; mRise = 0; mFall = 0; mLevel = 0;
    end else if (!cfgRun) begin
      mPre = 0; mCnt = 0; mLevel = 0;                      // R5
      mPer = cfgPeriod; mRise = cfgRise; mFall = cfgFall;  // R6
    end else begin
      int  qLen;
      bit  tick, wrap, nextLevel;
      qLen      = (int'(cfgDivLin) + 1) << cfgDivShift;    // R1
      tick      = (mPre >= qLen - 1);
      wrap      = tick && (mCnt >= mPer);                  // R2
      nextLevel = window(mCnt, mRise, mFall);              // R3, R4
      mPre      = tick ? 0 : mPre + 1;
      if (tick) mCnt = wrap ? 0 : mCnt + 1;
      if (cfgNoSync || wrap) begin                         // R9, R10
        mPer = cfgPeriod; mRise = cfgRise; mFall = cfgFall;
      end
      mLevel = nextLevel;
    end
    expQ.push_back(mLevel);
  end

  // monitor: compares the pins half a clock after each edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      bit lvl, expOut;
      lvl    = expQ.pop_front();
      expOut = (cfgDrive & lvl) ^ cfgInvert;               // R7, R8
      checks++;
      if (pwmOut !== expOut) begin
        errors++;
        $display("FAIL %s cycle %0d pwmOut=%0b expected %0b", phase, cycleNo, pwmOut, expOut);
      end
      checks++;
      if (pwmOe !== cfgDrive) begin
        errors++;
        $display("FAIL R7 cycle %0d pwmOe=%0b expected %0b", cycleNo, pwmOe, cfgDrive);
      end
      checks++;
      if (pwmLive !== expOut) begin
        errors++;
        $display("FAIL R11 cycle %0d pwmLive=%0b expected %0b", cycleNo, pwmLive, expOut);
      end
    end
  end

  always @(posedge clk) begin
    cycleNo++;
    if (cycleNo > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycleNo);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    cycles(3);
    rstN = 1'b1;
    phase = "R12"; cycles(5);
    phase = "R1";  cfgRun = 1'b1; cycles(80);
    phase = "R3";  cfgRise = 8'd6; cfgFall = 8'd2; cycles(80);
    phase = "R4";  cfgRise = 8'd5; cfgFall = 8'd5; cycles(70);
    phase = "R9";  cycles(5); cfgPeriod = 8'd4; cfgRise = 8'd1; cfgFall = 8'd3; cycles(90);
    phase = "R2";  cfgPeriod = 8'd0; cfgRise = 8'd0; cfgFall = 8'd1; cycles(30);
    cfgPeriod = 8'd2; cycles(40);
    phase = "R10"; cfgNoSync = 1'b1; cycles(3);
    cfgRise = 8'd2; cfgFall = 8'd0; cycles(7);
    cfgPeriod = 8'd9; cycles(60);
    cfgNoSync = 1'b0; cfgRise = 8'd3; cfgFall = 8'd7; cycles(60);
    phase = "R8";  cfgInvert = 1'b1; cycles(13);
    cfgInvert = 1'b0; cycles(7);
    cfgInvert = 1'b1; cycles(30);
    phase = "R7";  cfgDrive = 1'b0; cycles(25);
    cfgDrive = 1'b1; cfgInvert = 1'b0; cycles(20);
    phase = "R5";  cfgRun = 1'b0; cycles(10);
    phase = "R6";  cfgDivLin = 8'd0; cfgDivShift = 4'd2; cfgPeriod = 8'd3;
    cfgRise = 8'd1; cfgFall = 8'd3; cycles(4);
    cfgRun = 1'b1; cycles(60);
    phase = "R1";  cfgRun = 1'b0; cycles(2);
    cfgDivLin = 8'd2; cfgDivShift = 4'd0; cfgPeriod = 8'd5; cfgRise = 8'd0; cfgFall = 8'd2;
    cycles(2); cfgRun = 1'b1; cycles(60);
    cfgRun = 1'b0; cycles(2);
    cfgDivLin = 8'd0; cfgDivShift = 4'd0; cfgPeriod = 8'd3; cfgRise = 8'd1; cfgFall = 8'd2;
    cycles(2); cfgRun = 1'b1; cycles(40);
    cycles(1);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule